// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns an already decoded operand-addressing code into the 16-bit effective address of a memory operand. Each request carries a 3-bit mode code, a base register value, an index register value, a displacement or address field, a flag saying whether that field is 8 or 16 bits wide, and a select that picks base or index for the single-register forms. The register file and the instruction decoder sit outside the unit. Segment translation and the memory access itself are also outside.

Requests enter on a valid/ready port. Results leave through a single output register on a second valid/ready port. A request is taken on a rising clock edge when `in_valid` and `in_ready` are both high, and its result appears on the next cycle. `in_ready` is high when the output register is empty, or when its current result leaves on that same edge. A result stays on the outputs unchanged until `out_ready` takes it. Register-operand and immediate-operand requests still give a result beat, with a marker flag set and no address. A request with the unused mode code is taken and then dropped.

Top module: `ea_gen_unit`

## Requirements
- R1: Mode code 1 (direct) gives an address equal to the whole 16-bit `in_disp` field. The width flag has no effect in this mode.
- R2: Mode code 0 (immediate) gives a result beat with `out_imm_op`=1, `out_reg_op`=0 and `out_addr`=0.
- R3: Mode code 2 (register) gives a result beat with `out_reg_op`=1, `out_imm_op`=0 and `out_addr`=0.
- R4: Mode code 3 (register indirect) gives an address equal to `in_index` when `in_use_index`=1, and equal to `in_base` when `in_use_index`=0.
- R5: Mode code 4 (register relative) gives the register chosen as in R4 plus the displacement. With `in_disp_wide`=0, only bits 7:0 of `in_disp` are used, and they are sign-extended to 16 bits.
- R6: Mode code 5 (based indexed) gives `in_base` + `in_index`. The displacement has no effect in this mode.
- R7: Mode code 6 (relative based indexed) gives `in_base` + `in_index` + the displacement, with the displacement sized as in R5.
- R8: Every sum is taken modulo 2^16, and any carry out of bit 15 is discarded.
- R9: A request taken with mode code 7 gives no result beat. `out_valid` is low in the following cycle.
- R10: `out_valid` rises on the clock edge that takes a request, so the result is visible one cycle after the request strobe.
- R11: While `out_valid`=1 and `out_ready`=0, all result outputs hold their values and `in_ready` is low.
- R12: After reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_mode | input | 3 | Addressing mode code |
| in_use_index | input | 1 | Selects the index register (1) or the base register (0) for modes 3 and 4 |
| in_base | input | 16 | Base register value |
| in_index | input | 16 | Index register value |
| in_disp | input | 16 | Displacement, or the address field in direct mode |
| in_disp_wide | input | 1 | 1: 16-bit displacement, 0: 8-bit displacement in bits 7:0 |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 16 | Effective address (0 for register and immediate operands) |
| out_reg_op | output | 1 | Result marks a register operand |
| out_imm_op | output | 1 | Result marks an immediate operand |

## Verification
The bench builds the unit with its default parameter values: a 16-bit address and an 8-bit short displacement. At these widths, operands near 0xFFFF push every adder past bit 15, and short displacements of 0x80 and above test the sign extension. Upper bits left set in a short `in_disp` show that the top byte is ignored. Back-pressure comes from a fixed `out_ready` pattern, and requests with the unused code are sent between normal ones, so a dropped beat or an extra beat shows up in the ordered scoreboard.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    MODE_IMM    = 3'd0,
    MODE_DIRECT = 3'd1,
    MODE_REG    = 3'd2,
    MODE_RIND   = 3'd3,
    MODE_RREL   = 3'd4,
    MODE_BIDX   = 3'd5,
    MODE_BIDXD  = 3'd6,
    MODE_RSVD   = 3'd7
  } ea_mode_e;

  typedef struct packed {
    logic use_base;
    logic use_idx;
    logic use_disp;
    logic force_wide;
    logic is_reg;
    logic is_imm;
    logic legal;
  } ea_ctl_t;
endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
  import ea_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       use_index,
  output ea_ctl_t    ctl
);
  ea_mode_e m;
  assign m = ea_mode_e'(mode);

  always_comb begin
    ctl = '0;
    case (m)
      MODE_IMM: begin
        ctl.is_imm = 1'b1;
        ctl.legal  = 1'b1;
      end
      MODE_DIRECT: begin
        ctl.use_disp   = 1'b1;
        ctl.force_wide = 1'b1;
        ctl.legal      = 1'b1;
      end
      MODE_REG: begin
        ctl.is_reg = 1'b1;
        ctl.legal  = 1'b1;
      end
      MODE_RIND: begin
        ctl.use_base = !use_index;
        ctl.use_idx  = use_index;
        ctl.legal    = 1'b1;
      end
      MODE_RREL: begin
        ctl.use_base = !use_index;
        ctl.use_idx  = use_index;
        ctl.use_disp = 1'b1;
        ctl.legal    = 1'b1;
      end
      MODE_BIDX: begin
        ctl.use_base = 1'b1;
        ctl.use_idx  = 1'b1;
        ctl.legal    = 1'b1;
      end
      MODE_BIDXD: begin
        ctl.use_base = 1'b1;
        ctl.use_idx  = 1'b1;
        ctl.use_disp = 1'b1;
        ctl.legal    = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic [ADDR_W-1:0] disp_in,
  input  logic              wide,
  output logic [ADDR_W-1:0] disp_out
);
  localparam int EXT_W = ADDR_W - SHORT_W;

  generate
    if (EXT_W > 0) begin : g_ext
      logic [ADDR_W-1:0] short_ext;
      assign short_ext = {{EXT_W{disp_in[SHORT_W-1]}}, disp_in[SHORT_W-1:0]};
      assign disp_out  = wide ? disp_in : short_ext;
    end else begin : g_pass
      logic unused_wide;
      assign unused_wide = wide;
      assign disp_out    = disp_in;
    end
  endgenerate
endmodule

// File: rtl/ea_adder3.sv
module ea_adder3 #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum
);
  logic [W-1:0] ab;
  assign ab  = a + b;
  assign sum = ab + c;
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
  import ea_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_mode,
  input  logic              in_use_index,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] in_index,
  input  logic [ADDR_W-1:0] in_disp,
  input  logic              in_disp_wide,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_reg_op,
  output logic              out_imm_op
);
  ea_ctl_t           ctl;
  logic [ADDR_W-1:0] disp_x;
  logic [ADDR_W-1:0] op_b, op_i, op_d;
  logic [ADDR_W-1:0] ea_sum;

  ea_mode_dec u_dec (
    .mode      (in_mode),
    .use_index (in_use_index),
    .ctl       (ctl)
  );

  ea_disp_ext #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_ext (
    .disp_in  (in_disp),
    .wide     (in_disp_wide | ctl.force_wide),
    .disp_out (disp_x)
  );

  assign op_b = ctl.use_base ? in_base  : '0;
  assign op_i = ctl.use_idx  ? in_index : '0;
  assign op_d = ctl.use_disp ? disp_x   : '0;

  ea_adder3 #(.W(ADDR_W)) u_add (
    .a   (op_b),
    .b   (op_i),
    .c   (op_d),
    .sum (ea_sum)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_reg_op <= 1'b0;
      out_imm_op <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid && ctl.legal;
      if (in_valid) begin
        out_addr   <= ea_sum;
        out_reg_op <= ctl.is_reg;
        out_imm_op <= ctl.is_imm;
      end
    end
  end

  // R11: a stalled beat keeps its contents
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                   && $stable(out_reg_op) && $stable(out_imm_op)));

  // R9: unused code yields no beat
  assert_unused_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == 3'd7) |=> !out_valid);

  // R2 / R3: operand markers carry no address
  assert_marker_noaddr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_reg_op || out_imm_op)) |-> (out_addr == '0));

  // R2: at most one marker per beat
  assert_marker_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_reg_op, out_imm_op}));

  // R10: a beat only appears after an accepted request
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

// File: tb/test_ea_gen_unit.sv
module test_ea_gen_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_mode = '0;
  logic        in_use_index = 1'b0;
  logic [15:0] in_base = '0, in_index = '0, in_disp = '0;
  logic        in_disp_wide = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_addr;
  logic        out_reg_op, out_imm_op;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp_on = 1'b0;
  logic [17:0] exp_q[$];

  always #2.5 clk = ~clk;

  ea_gen_unit i_ea_gen_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_use_index(in_use_index), .in_base(in_base),
    .in_index(in_index), .in_disp(in_disp), .in_disp_wide(in_disp_wide),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_reg_op(out_reg_op), .out_imm_op(out_imm_op)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] model(input logic [2:0] m, input logic ui,
      input logic [15:0] b, input logic [15:0] x, input logic [15:0] d, input logic w);
    logic [15:0] dx, r;
    dx = w ? d : {{8{d[7]}}, d[7:0]};
    r  = ui ? x : b;
    case (m)
      3'd0: return {16'h0, 1'b0, 1'b1};
      3'd1: return {d, 2'b00};
      3'd2: return {16'h0, 1'b1, 1'b0};
      3'd3: return {r, 2'b00};
      3'd4: return {16'(r + dx), 2'b00};
      3'd5: return {16'(b + x), 2'b00};
      default: return {16'(b + x + dx), 2'b00};
    endcase
  endfunction

  task automatic send(input logic [2:0] m, input logic ui, input logic [15:0] b,
      input logic [15:0] x, input logic [15:0] d, input logic w, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_use_index = ui;
    in_base = b; in_index = x; in_disp = d; in_disp_wide = w;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    if (m != 3'd7) exp_q.push_back(model(m, ui, b, x, d, w));
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    if (!bp_on) begin
      if (m == 3'd7) check(out_valid == 1'b0, {"R9 ", req}, out_valid, 0);
      else check(out_valid == 1'b1, {"R10 ", req}, out_valid, 1);
    end
  endtask

  // ready pattern driven just after each edge
  always @(posedge clk) begin
    cyc++;
    #1;
    out_ready = bp_on ? (cyc % 3 == 0) : 1'b1;
  end

  // monitor: scoreboard and stall hold check
  logic        stalled = 1'b0;
  logic [17:0] stall_val;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) begin
        check(out_valid && {out_addr, out_reg_op, out_imm_op} == stall_val,
              "R11 stall hold", {out_valid, out_addr, out_reg_op, out_imm_op}, {1'b1, stall_val});
        check(in_ready == 1'b0 || out_ready, "R11 ready low in stall", in_ready, 0);
      end
      stalled = out_valid && !out_ready;
      stall_val = {out_addr, out_reg_op, out_imm_op};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected beat", {out_addr, out_reg_op, out_imm_op}, 0);
        end else begin
          logic [17:0] e;
          e = exp_q.pop_front();
          check({out_addr, out_reg_op, out_imm_op} == e, "R1-set scoreboard",
                {out_addr, out_reg_op, out_imm_op}, e);
        end
      end
    end
  end

  initial begin
    #50000;
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R12 out_valid after reset", out_valid, 0);
    rst_n = 1'b1;
    #1;
    check(in_ready == 1'b1, "R12 in_ready after reset", in_ready, 1);

    send(3'd1, 0, 16'h1111, 16'h2222, 16'hABCD, 0, "R1 direct narrow flag");
    send(3'd1, 1, 16'h0, 16'h0, 16'h00F0, 1, "R1 direct");
    send(3'd0, 0, 16'h1234, 16'h5678, 16'h9ABC, 1, "R2 immediate");
    send(3'd2, 1, 16'h1234, 16'h5678, 16'h9ABC, 0, "R3 register");
    send(3'd3, 0, 16'hBEEF, 16'h0F0F, 16'h1234, 1, "R4 via base");
    send(3'd3, 1, 16'hBEEF, 16'h0F0F, 16'h1234, 1, "R4 via index");
    send(3'd4, 0, 16'h0010, 16'h7777, 16'h12F0, 0, "R5 negative short");
    send(3'd4, 1, 16'h1111, 16'h0100, 16'h007F, 0, "R5 positive short");
    send(3'd4, 0, 16'h1000, 16'h0, 16'h8000, 1, "R5 wide disp");
    send(3'd7, 0, 16'h1, 16'h2, 16'h3, 1, "R9 unused code");
    send(3'd5, 0, 16'hFFFF, 16'h0002, 16'h5555, 1, "R6 R8 wrap");
    send(3'd6, 0, 16'h1000, 16'h0200, 16'h0080, 0, "R7 short disp");
    send(3'd6, 0, 16'hFFF0, 16'h0020, 16'hFFF0, 1, "R7 R8 wrap");

    bp_on = 1'b1;
    for (int k = 0; k < 24; k++) begin
      logic [15:0] bb, xx, dd;
      bb = 16'(k * 16'h0B3D + 16'hF000);
      xx = 16'(k * 16'h1357);
      dd = 16'(k * 16'h2F81);
      send(3'(k % 8), k[0], bb, xx, dd, k[1], "R11 back-pressure mix");
    end
    bp_on = 1'b0;

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R9 all beats drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule